// File: doc/BRIEF.md
# External Edge Interrupt Request Unit

This block watches six asynchronous interrupt pins and turns qualifying transitions on them into latched request flags. Each pin first passes through a two-flop synchroniser. A transition is then found by comparing the current synchronised sample with the one before it. A channel either reacts to one chosen edge, selected by a polarity bit, or reacts to both edges. The two highest channels share their request lines with other sources, so they only raise requests while a route bit selects them.

Software programs the block through a small register port. Address 0 holds the 8-bit mode register, and addresses 1 to 6 hold the control registers of channels 0 to 5. A latched flag drives the channel's request output only while the channel's priority field is non-zero. The flag stays set until software writes 0 to it or the acknowledge input for that channel clears it.

Top module: `ext_edge_irq`

## Requirements
- R1: After reset the mode register and all six control registers read 0x00, and all `irq_req` bits are 0. The synchroniser resets high, so pins held high raise no request after reset.
- R2: With mode bit i = 0 and polarity 0, a falling edge on `pin_in[i]` sets flag i and a rising edge does not.
- R3: With mode bit i = 0 and polarity 1, a rising edge sets flag i and a falling edge does not.
- R4: Mode bits 0 to 5 put channels 0 to 5 into both-edge mode. In that mode either edge sets the flag, whatever the polarity bit holds.
- R5: Channel 4 sets its flag only while mode bit 6 is 1, and channel 5 sets its flag only while mode bit 7 is 1. Channels 0 to 3 are not affected by these bits.
- R6: A set flag stays set until it is cleared. Writing a control register with bit 3 = 0 clears the flag. Writing bit 3 = 1 leaves the flag unchanged, so software can never set it.
- R7: A one-cycle pulse on `irq_ack[i]` clears flag i.
- R8: When a qualifying edge and a clear arrive in the same cycle, the flag ends up set.
- R9: `irq_req[i]` is 1 exactly when flag i is set and the priority field (control bits 2:0) is non-zero.
- R10: The control register layout is bits 2:0 priority, bit 3 live request flag, bit 4 polarity, and bits 7:5 read 0. `reg_rdata` is combinational, and addresses 7 and above read 0x00.
- R11: A pin change that is set up before clock edge k shows as a set flag after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 = mode, 1..6 = channel 0..5 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pin_in | input | 6 | Asynchronous interrupt pins |
| irq_ack | input | 6 | Per-channel acknowledge, clears the flag |
| irq_req | output | 6 | Per-channel interrupt request |

## Verification
Falling and rising transitions are driven in turn under each edge setting. This shows whether the polarity bit selects the right edge and whether both-edge mode overrides it. The shared channels are pulsed with their route bit cleared and then set, which separates a gated channel from an ungated one. Acknowledge pulses and flag writes are timed to land on the same cycle as a detected edge, which shows that the set takes priority over the clear. A flag held with a zero priority shows that the request output is masked while the flag itself is kept.

// File: rtl/ext_edge_irq.sv
module ext_edge_irq #(
  parameter int NCH = 6,
  parameter int PW  = 3,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] pin_in,
  input  logic [NCH-1:0] irq_ack,
  output logic [NCH-1:0] irq_req
);
  localparam int MW = NCH + 2;
  localparam int FB = PW;
  localparam int PB = PW + 1;

  logic [NCH-1:0] s1, s2, s3;
  logic [MW-1:0]  mode;
  logic [NCH-1:0] flag, pol, hit, clr, route;
  logic [PW-1:0]  prio [NCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '1;
    else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= '0;
    else if (reg_we && reg_addr == '0) mode <= reg_wdata[MW-1:0];

  assign route = {mode[NCH+1], mode[NCH], {(NCH-2){1'b1}}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire rise = s2[i] & ~s3[i];
    wire fall = ~s2[i] & s3[i];
    wire wsel = reg_we && reg_addr == AW'(i + 1);

    assign hit[i] = route[i] & (mode[i] ? (rise | fall) : (pol[i] ? rise : fall));
    assign clr[i] = irq_ack[i] | (wsel & ~reg_wdata[FB]);
    assign irq_req[i] = flag[i] & (prio[i] != '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        flag[i] <= 1'b0;
        pol[i]  <= 1'b0;
        prio[i] <= '0;
      end else begin
        if (hit[i]) flag[i] <= 1'b1;
        else if (clr[i]) flag[i] <= 1'b0;
        if (wsel) begin
          pol[i]  <= reg_wdata[PB];
          prio[i] <= reg_wdata[PW-1:0];
        end
      end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = 8'(mode);
    for (int i = 0; i < NCH; i++)
      if (reg_addr == AW'(i + 1)) reg_rdata = 8'({pol[i], flag[i], prio[i]});
  end
endmodule

// File: rtl/ext_edge_irq_chk.sv
module ext_edge_irq_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [NCH+1:0] mode,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] s2,
  input logic [NCH-1:0] s3,
  input logic [NCH-1:0] irq_ack,
  input logic [NCH-1:0] irq_req
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_req[i] |-> flag[i]); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (flag[i] && !irq_ack[i] && !reg_we) |=> flag[i]); // R6
    AST_SET_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[i]) |-> $past(s2[i] ^ s3[i])); // R11
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack[i] && !(s2[i] ^ s3[i])) |=> !flag[i]); // R7
  end
  AST_GATE_CH4: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[NCH-2]) |-> $past(mode[NCH])); // R5
  AST_GATE_CH5: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag[NCH-1]) |-> $past(mode[NCH+1])); // R5
endmodule

bind ext_edge_irq ext_edge_irq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mode(mode), .flag(flag),
  .s2(s2), .s3(s3), .irq_ack(irq_ack), .irq_req(irq_req)
);

// File: tb/ext_edge_irq_tb.sv
module ext_edge_irq_tb;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [5:0] pin_in = '1, irq_ack = '0, irq_req;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ext_edge_irq u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk); pin_in[i] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 8'h00, "R1 reset value");
    chk(irq_req == 0, "R1 req idle", irq_req, 0);
  endtask

  task automatic t_fall;
    wr(1, 8'h01);
    @(negedge clk); pin_in[0] = 0;
    repeat (2) @(negedge clk);
    rd_chk(1, 8'h01, "R11 not yet set");
    @(negedge clk);
    rd_chk(1, 8'h09, "R2 falling sets");
    chk(irq_req[0], "R9 req ch0", irq_req, 1);
    wr(1, 8'h01);
    pin(0, 1);
    rd_chk(1, 8'h01, "R2 rising ignored");
  endtask

  task automatic t_rise;
    wr(2, 8'h11);
    pin(1, 0);
    rd_chk(2, 8'h11, "R3 falling ignored");
    pin(1, 1);
    rd_chk(2, 8'h19, "R3 rising sets");
    wr(2, 8'h11);
  endtask

  task automatic t_both;
    wr(0, 8'h04); wr(3, 8'h01);
    pin(2, 0);
    rd_chk(3, 8'h09, "R4 both fall");
    wr(3, 8'h01);
    pin(2, 1);
    rd_chk(3, 8'h09, "R4 both rise");
    wr(3, 8'h11);
    pin(2, 0);
    rd_chk(3, 8'h19, "R4 pol1 override fall");
    pin(2, 1);
    wr(3, 8'h00); wr(0, 8'h00);
  endtask

  task automatic t_gate;
    wr(5, 8'h01); wr(6, 8'h01);
    pin(4, 0); pin(5, 0);
    rd_chk(5, 8'h01, "R5 ch4 gated");
    rd_chk(6, 8'h01, "R5 ch5 gated");
    chk(irq_req[5:4] == 0, "R5 no req", irq_req, 0);
    pin(4, 1); pin(5, 1);
    wr(0, 8'hC0);
    pin(4, 0); pin(5, 0);
    rd_chk(5, 8'h09, "R5 ch4 routed");
    rd_chk(6, 8'h09, "R5 ch5 routed");
    rd_chk(0, 8'hC0, "R10 mode readback");
    pin(4, 1); pin(5, 1);
    wr(5, 8'h00); wr(6, 8'h00); wr(0, 8'h00);
  endtask

  task automatic t_hold;
    wr(4, 8'h01);
    pin(3, 0);
    repeat (10) @(negedge clk);
    rd_chk(4, 8'h09, "R6 flag held");
    wr(4, 8'h09);
    rd_chk(4, 8'h09, "R6 write1 keeps");
    wr(4, 8'h01);
    rd_chk(4, 8'h01, "R6 write0 clears");
    wr(4, 8'h09);
    rd_chk(4, 8'h01, "R6 write1 no set");
    pin(3, 1);
  endtask

  task automatic t_ack;
    pin(0, 0);
    rd_chk(1, 8'h09, "R7 pre-set");
    @(negedge clk); irq_ack[0] = 1;
    @(negedge clk); irq_ack[0] = 0;
    rd_chk(1, 8'h01, "R7 ack clears");
    chk(!irq_req[0], "R7 req dropped", irq_req, 0);
    pin(0, 1);
  endtask

  task automatic t_setwins;
    pin(0, 0);
    pin(0, 1);
    @(negedge clk); pin_in[0] = 0;
    repeat (2) @(negedge clk);
    irq_ack[0] = 1;
    @(negedge clk); irq_ack[0] = 0;
    rd_chk(1, 8'h09, "R8 set wins");
    @(negedge clk); irq_ack[0] = 1;
    @(negedge clk); irq_ack[0] = 0;
    pin(0, 1);
  endtask

  task automatic t_prio;
    wr(2, 8'h00);
    pin(1, 0);
    rd_chk(2, 8'h08, "R9 flag kept prio0");
    chk(!irq_req[1], "R9 masked", irq_req, 0);
    wr(2, 8'h0D);
    rd_chk(2, 8'h0D, "R10 ctrl layout");
    chk(irq_req[1], "R9 unmasked", irq_req, 1);
    rd_chk(7, 8'h00, "R10 unused addr");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_fall; t_rise; t_both; t_gate; t_hold; t_ack; t_setwins; t_prio;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule